// File: doc/BRIEF.md
# Shared-Line Sound DSP Interrupt Request Handshake

This block holds the interrupt-request logic of a sound DSP whose request output is one of several sub-lines merged onto a single interrupt input. The host drives a small read/write register port. The block raises its request when a DMA block completes. It also raises it a fixed 10 microseconds after the host writes the interrupt-test command `0xF2`. A shared-line arbiter pulses an acknowledge when it grants this sub-line into the interrupt controller's request register.

The request is tracked by a three-state flag: idle (0), raised (2) and raised-and-acknowledged (3). A host read of the status offset `0xE` consumes the interrupt only after the arbiter has granted it. Such a read resumes the paused DMA transfer, drops the request and returns the flag to idle. In any other state the same read only reports whether the output buffer holds a byte.

A constant output carries the packed line code of the request. The shared sub-line number is in the high nibble and the interrupt input number is in the low nibble.

Top module: `dsp_irq_handshake`

## Requirements
- R1: After reset, `irqReq` and `dmaResume` are 0. A read at offset 0xE returns 0x7F.
- R2: A write of 0xF2 to offset 0xC sets `irqReq` exactly 10*CYCLES_PER_US cycles after the write edge, and not earlier. Any other command byte never sets it.
- R3: A `blockDone` strobe while idle sets `irqReq` on the next cycle.
- R4: An `irqAck` while the flag is raised moves the flag to acknowledged, and `irqReq` stays high.
- R5: A read of 0xE while acknowledged gives a one-cycle `dmaResume` pulse on the next cycle. On that same cycle `irqReq` drops and the flag returns to idle.
- R6: A read of 0xE while idle or raised causes no `dmaResume` pulse and leaves `irqReq` unchanged.
- R7: An `irqAck` while idle is ignored. A later request with no acknowledge is then not consumed by a status read.
- R8: A read at 0xE returns the output-buffer-full status in bit 7, and all other bits are 1. A read at 0xA returns the buffered byte and empties the buffer. Every other offset reads 0xFF.
- R9: Command 0xF2 never places a byte in the output buffer, so status bit 7 stays 0.
- R10: A write at offset 0x6 with bit 0 set resets the DSP side. The flag becomes idle, `irqReq` drops on the next cycle, a pending 0xF2 delay is cancelled and the output buffer empties.
- R11: `lineCode` equals {SUB_LINE, IR_LINE}, which is 0x35 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (side effects) |
| hostAddr | input | 4 | Register offset |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data (combinational on hostAddr) |
| replyValid | input | 1 | Load a reply byte into the output buffer |
| replyData | input | 8 | Reply byte |
| blockDone | input | 1 | DMA block finished strobe |
| irqAck | input | 1 | Arbiter grant pulse for this sub-line |
| irqReq | output | 1 | Shared sub-line request |
| dmaResume | output | 1 | One-cycle DMA resume pulse |
| lineCode | output | 8 | Packed sub-line / IR code |

## Verification
On every cycle, the assertions check the following. The flag only takes its three legal encodings. A resume pulse lasts one cycle and coincides with a dropped request. A resume only follows a status read made while a request was pending. An acknowledge of a raised request always reaches the acknowledged state, and a DSP reset always leaves the line low. The bench scenarios show the rest. They check the exact 10-microsecond delay and that only 0xF2 starts it, and that status reads in the idle and raised states have no effect. They also check the read values of every offset, and that 0xF2 leaves the output buffer empty.

// File: rtl/dsp_irq_pkg.sv
package dsp_irq_pkg;
  typedef enum logic [1:0] {
    FLAG_IDLE   = 2'd0,
    FLAG_RAISED = 2'd2,
    FLAG_ACKED  = 2'd3
  } irqFlag_t;

  typedef struct packed {
    logic popBuf;
    logic dspReset;
  } ctrlStrobes_t;

  localparam logic [3:0] OFF_RESET  = 4'h6;
  localparam logic [3:0] OFF_DATA   = 4'hA;
  localparam logic [3:0] OFF_CMD    = 4'hC;
  localparam logic [3:0] OFF_STATUS = 4'hE;
  localparam logic [7:0] CMD_IRQ_TEST = 8'hF2;
endpackage

// File: rtl/dsp_irq_ctrl.sv
module dsp_irq_ctrl
  import dsp_irq_pkg::*;
#(
  parameter int CYCLES_PER_US = 8,
  parameter int DELAY_US = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostWr,
  input  logic hostRd,
  input  logic [3:0] hostAddr,
  input  logic [7:0] hostWrData,
  input  logic blockDone,
  input  logic irqAck,
  output ctrlStrobes_t strobes,
  output logic irqReq,
  output logic dmaResume,
  output irqFlag_t flagState
);
  localparam int DELAY_CYCLES = DELAY_US * CYCLES_PER_US;
  localparam int TW = $clog2(DELAY_CYCLES + 1);

  logic [TW-1:0] timer;
  logic cmdTest, statusRead, timerFire, trigger;
  irqFlag_t flagNext;

  assign cmdTest    = hostWr && hostAddr == OFF_CMD && hostWrData == CMD_IRQ_TEST;
  assign statusRead = hostRd && hostAddr == OFF_STATUS;
  assign timerFire  = timer == TW'(1);
  assign trigger    = timerFire || blockDone;

  always_comb begin
    strobes.dspReset = hostWr && hostAddr == OFF_RESET && hostWrData[0];
    strobes.popBuf   = hostRd && hostAddr == OFF_DATA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (strobes.dspReset) timer <= '0;
    else if (cmdTest) timer <= TW'(DELAY_CYCLES);
    else if (timer != '0) timer <= timer - TW'(1);
  end

  always_comb begin
    flagNext = flagState;
    unique case (flagState)
      FLAG_IDLE:   if (trigger) flagNext = FLAG_RAISED;
      FLAG_RAISED: if (irqAck) flagNext = FLAG_ACKED;
      FLAG_ACKED:  if (statusRead) flagNext = FLAG_IDLE;
      default:     flagNext = FLAG_IDLE;
    endcase
    if (strobes.dspReset) flagNext = FLAG_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagState <= FLAG_IDLE;
      irqReq    <= 1'b0;
      dmaResume <= 1'b0;
    end else begin
      flagState <= flagNext;
      irqReq    <= flagNext != FLAG_IDLE;
      dmaResume <= !strobes.dspReset && flagState == FLAG_ACKED && statusRead;
    end
  end
endmodule

// File: rtl/dsp_irq_dp.sv
module dsp_irq_dp
  import dsp_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic [3:0] hostAddr,
  input  logic replyValid,
  input  logic [7:0] replyData,
  output logic [7:0] hostRdData
);
  logic bufFull;
  logic [7:0] bufByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufByte <= '0;
    end else if (strobes.dspReset) begin
      bufFull <= 1'b0;
    end else if (replyValid) begin
      bufFull <= 1'b1;
      bufByte <= replyData;
    end else if (strobes.popBuf) begin
      bufFull <= 1'b0;
    end
  end

  always_comb begin
    unique case (hostAddr)
      OFF_STATUS: hostRdData = {bufFull, 7'h7F};
      OFF_DATA:   hostRdData = bufByte;
      default:    hostRdData = 8'hFF;
    endcase
  end
endmodule

// File: rtl/dsp_irq_handshake.sv
module dsp_irq_handshake
  import dsp_irq_pkg::*;
#(
  parameter int CYCLES_PER_US = 8,
  parameter logic [3:0] SUB_LINE = 4'd3,
  parameter logic [3:0] IR_LINE = 4'd5
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostWr,
  input  logic hostRd,
  input  logic [3:0] hostAddr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  input  logic replyValid,
  input  logic [7:0] replyData,
  input  logic blockDone,
  input  logic irqAck,
  output logic irqReq,
  output logic dmaResume,
  output logic [7:0] lineCode
);
  ctrlStrobes_t strobes;
  irqFlag_t flagState;

  assign lineCode = {SUB_LINE, IR_LINE};

  dsp_irq_ctrl #(.CYCLES_PER_US(CYCLES_PER_US), .DELAY_US(10)) ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .blockDone(blockDone),
    .irqAck(irqAck), .strobes(strobes), .irqReq(irqReq),
    .dmaResume(dmaResume), .flagState(flagState)
  );

  dsp_irq_dp dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .replyValid(replyValid), .replyData(replyData), .hostRdData(hostRdData)
  );
endmodule

// File: rtl/dsp_irq_handshake_sva.sv
module dsp_irq_handshake_sva
  import dsp_irq_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic hostWr,
  input logic hostRd,
  input logic [3:0] hostAddr,
  input logic [7:0] hostWrData,
  input logic irqAck,
  input logic irqReq,
  input logic dmaResume,
  input logic [1:0] flagBits
);
  assert_flag_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    flagBits != 2'd1);

  assert_resume_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    dmaResume |=> !dmaResume);

  assert_resume_drops_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    dmaResume |-> !irqReq);

  assert_resume_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaResume) |-> $past(hostRd && hostAddr == OFF_STATUS && irqReq));

  assert_ack_advances_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagBits == 2'd2 && irqAck && !(hostWr && hostAddr == OFF_RESET && hostWrData[0]))
      |=> (flagBits == 2'd3 && irqReq));

  assert_reset_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == OFF_RESET && hostWrData[0]) |=> (!irqReq && flagBits == 2'd0));
endmodule

bind dsp_irq_handshake dsp_irq_handshake_sva chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .irqAck(irqAck), .irqReq(irqReq),
  .dmaResume(dmaResume), .flagBits(flagState)
);

// File: tb/dsp_irq_handshake_test.sv
module dsp_irq_handshake_test;
  localparam int CPU = 2;
  localparam int DELAY = 10 * CPU;

  logic clk = 0, rstN = 0;
  logic hostWr = 0, hostRd = 0, replyValid = 0, blockDone = 0, irqAck = 0;
  logic [3:0] hostAddr = 0;
  logic [7:0] hostWrData = 0, replyData = 0;
  logic [7:0] hostRdData, lineCode;
  logic irqReq, dmaResume;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dsp_irq_handshake #(.CYCLES_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .replyValid(replyValid),
    .replyData(replyData), .blockDone(blockDone), .irqAck(irqAck),
    .irqReq(irqReq), .dmaResume(dmaResume), .lineCode(lineCode)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    hostWr = 1; hostAddr = a; hostWrData = d; step(); hostWr = 0;
  endtask

  task automatic rd(logic [3:0] a);
    hostRd = 1; hostAddr = a; step(); hostRd = 0;
  endtask

  task automatic ack();
    irqAck = 1; step(); irqAck = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] v);
    hostAddr = a; #0.5; v = hostRdData;
  endtask

  initial begin
    #20000000;
    fails++; $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) step();
    // R1 reset state
    check("R1 irqReq", irqReq, 0);
    check("R1 dmaResume", dmaResume, 0);
    peek(4'hE, v); check("R1 status", v, 8'h7F);
    rstN = 1; step();
    // R11 line code
    check("R11 lineCode", lineCode, 8'h35);

    // R2 and R9: sweep every command byte
    for (int cmd = 0; cmd < 256; cmd++) begin
      wr(4'hC, cmd[7:0]);
      for (int k = 1; k <= DELAY + 2; k++) begin
        step();
        if (k == DELAY - 1 || k == DELAY)
          check("R2 delay edge", irqReq, (cmd == 8'hF2 && k == DELAY) ? 1 : 0);
      end
      check("R2 after delay", irqReq, cmd == 8'hF2);
      peek(4'hE, v); check("R9 status bit7", v, 8'h7F);
      if (irqReq) begin
        ack(); rd(4'hE);
        check("R5 resume", dmaResume, 1);
        check("R5 req dropped", irqReq, 0);
        step(); check("R5 single pulse", dmaResume, 0);
      end
    end

    // R3, R6, R4, R5 sequence
    blockDone = 1; step(); blockDone = 0;
    check("R3 raised", irqReq, 1);
    rd(4'hE); check("R6 no resume raised", dmaResume, 0);
    check("R6 req kept", irqReq, 1);
    ack(); check("R4 req kept", irqReq, 1);
    rd(4'hD); check("R6 other offset no resume", dmaResume, 0);
    rd(4'hE); check("R5 resume", dmaResume, 1);
    check("R5 drop", irqReq, 0);
    rd(4'hE); check("R6 idle no resume", dmaResume, 0);
    check("R6 idle req", irqReq, 0);

    // R7 ack in idle ignored
    ack(); blockDone = 1; step(); blockDone = 0;
    rd(4'hE); check("R7 no resume without ack", dmaResume, 0);
    check("R7 req held", irqReq, 1);
    ack(); rd(4'hE); check("R7 resume after ack", dmaResume, 1);

    // R8 read map sweep
    replyValid = 1; replyData = 8'h5C; step(); replyValid = 0;
    for (int a = 0; a < 16; a++) begin
      peek(a[3:0], v);
      check("R8 read map", v, a == 14 ? 8'hFF : a == 10 ? 8'h5C : 8'hFF);
    end
    rd(4'hA);
    peek(4'hE, v); check("R8 buffer emptied", v, 8'h7F);

    // R10 reset cancels pending delay and request
    replyValid = 1; replyData = 8'h11; step(); replyValid = 0;
    wr(4'hC, 8'hF2);
    repeat (3) step();
    wr(4'h6, 8'h01);
    peek(4'hE, v); check("R10 buffer cleared", v, 8'h7F);
    repeat (DELAY + 3) step();
    check("R10 delay cancelled", irqReq, 0);
    blockDone = 1; step(); blockDone = 0;
    wr(4'h6, 8'h01); check("R10 req dropped", irqReq, 0);
    wr(4'h6, 8'h00); check("R10 bit0 clear no reset", irqReq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule